// File: doc/BRIEF.md
# Configuration Key-Unlock Controller

This block guards an indexed configuration register file behind a host I/O port. It sees already-decoded single-byte I/O read and write strobes with a 16-bit address. After reset it is locked. It opens only after a four-byte key is written to the fixed key address 002Eh. The last key byte chooses which index/data address pair becomes live: 002Eh/002Fh or 004Eh/004Fh.

While the block is open, a write to the index address selects a register, and a read of the index address returns that selection. Accesses to the data address then read or write the selected register. The block owns a small set of global registers:

- a write-only exit control;
- a logical device number;
- two fixed identification bytes;
- a version byte that also carries a write-only strap-compare field.

Indexes from 30h upward are device registers. The block forwards them to an external register file over a strobe interface, but only while the logical device number equals the device number set by a parameter.

A 2-bit strap value is captured from pins while reset is held. A write to the strap-compare field that does not match this captured value closes the block. This lets several identical parts share one key, with only the part whose straps match staying open.

Top module: `cfg_unlock_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it, `cfg_open` is 0, the selected index is 00h and the logical device number is 00h.
- R2: Writing 87h, 06h, 55h, 55h to 002Eh opens the block with index/data at 002Eh/002Fh. Writing 87h, 06h, 55h, AAh opens it with index/data at 004Eh/004Fh. `cfg_open` is high in the cycle after the fourth write. A fourth byte of any other value leaves the block locked, and the pair that was not chosen reads 00h.
- R3: While locked, any read cycle, any write to another address, or a wrong key byte (including a repeated 87h) restarts key entry. The next correct byte is then taken as the first key byte.
- R4: While open, a data write to index 02h with bit 1 set closes the block in the next cycle. The same write with bit 1 clear has no effect. Index 02h reads 00h.
- R5: Index 07h is a read/write logical device number, reset value 00h. Index 30h–FFh data accesses reach the device port (`dev_wr`/`dev_rd` pulse, `dev_idx` = index, `dev_wdata` = written byte, read data = `dev_rdata`) only while the device number equals 10h. Otherwise they read 00h and raise no strobe.
- R6: Index 20h reads 87h and index 21h reads 06h. Writes to either have no effect.
- R7: Index 22h reads 00h: bits 3..0 are the version (0h) and bits 5..4 read as 0. A data write to index 22h whose bits 5..4 differ from the captured strap closes the block in the next cycle. A write whose bits 5..4 match leaves it open.
- R8: The strap value is taken from `strap_pins` on every clock edge while `rst_n` is low and held unchanged afterwards. Later pin changes do not affect the compare in R7.
- R9: While locked, reads of 002Eh, 002Fh, 004Eh and 004Fh return FFh. Writes to 002Fh, 004Eh and 004Fh change neither the index nor any register.
- R10: While open, reading the live index address returns the last byte written to it, for all 256 values.
- R11: Index values 00h–2Fh other than 02h, 07h, 20h, 21h and 22h read 00h, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr | input | 1 | Single-byte I/O write strobe |
| io_rd | input | 1 | Single-byte I/O read strobe |
| io_addr | input | 16 | I/O address of the current cycle |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Read data byte, valid while io_rd is high |
| strap_pins | input | 2 | Multi-part strap pins, captured during reset |
| cfg_open | output | 1 | High while the configuration ports are unlocked |
| dev_wr | output | 1 | Device register write strobe |
| dev_rd | output | 1 | Device register read strobe |
| dev_idx | output | 8 | Device register index |
| dev_wdata | output | 8 | Device register write data |
| dev_rdata | input | 8 | Device register read data |

## Verification
Two functions can fall in the same cycle. A data write that relocks the block (exit bit or strap mismatch) is, in that same cycle, an I/O cycle that the key checker also sees. In the same way, a locked-state write to a data address is both an ignored register write and a foreign cycle that restarts key entry. The bench provokes both cases. It relocks and then starts a new key on the very next cycle, expecting the block to open again. It writes to locked data and index addresses between key sequences, then expects that no register or index moved and that a following full key still opens the block. The sweeps cover every fourth key byte, every index readback value, every global index and every strap-compare value, with expected results worked out from the requirement text.

// File: rtl/cfg_unlock_pkg.sv
// Package: shared state type and fixed index/field positions of the
// configuration unlock controller. Assumes 8-bit configuration data.
package cfg_unlock_pkg;

    localparam int DATA_W    = 8;
    localparam int STRAP_W   = 2;
    localparam int STRAP_LSB = 4;   // strap-compare field position in index 22h
    localparam int EXIT_BIT  = 1;   // relock control bit in index 02h

    localparam logic [DATA_W-1:0] IDX_EXIT     = 8'h02;
    localparam logic [DATA_W-1:0] IDX_LDN      = 8'h07;
    localparam logic [DATA_W-1:0] IDX_ID_HI    = 8'h20;
    localparam logic [DATA_W-1:0] IDX_ID_LO    = 8'h21;
    localparam logic [DATA_W-1:0] IDX_VER      = 8'h22;
    localparam logic [DATA_W-1:0] IDX_DEV_BASE = 8'h30;

    typedef enum logic [2:0] {
        KS_IDLE,
        KS_GOT1,
        KS_GOT2,
        KS_GOT3,
        KS_OPEN
    } key_state_e;

endpackage

// File: rtl/cfg_strap_latch.sv
// Strap latch: follows the strap pins while reset is held and freezes
// them afterwards. Assumes the pins are stable at the end of reset.
module cfg_strap_latch
    import cfg_unlock_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap_pins,
    output logic [STRAP_W-1:0] strap_q
);

    // Capture pins during reset, hold after release.
    always_ff @(posedge clk) begin
        if (!rst_n) strap_q <= strap_pins;
    end

    AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(strap_q)); // R8

endmodule

// File: rtl/cfg_key_fsm.sv
// Key checker: counts correct key bytes written to the key address
// while locked, restarts on any other I/O cycle, opens on the last byte
// and records which port pair that byte chose. Assumes io_wr and io_rd
// are never high together.
module cfg_key_fsm
    import cfg_unlock_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] KEY_ADDR = 'h2E,
    parameter logic [7:0]        KEY_B0   = 8'h87,
    parameter logic [7:0]        KEY_B1   = 8'h06,
    parameter logic [7:0]        KEY_B2   = 8'h55,
    parameter logic [7:0]        KEY_SEL0 = 8'h55,
    parameter logic [7:0]        KEY_SEL1 = 8'hAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              relock,
    output logic              open,
    output logic              pair_sel
);

    key_state_e st_q, st_nx;
    logic       sel_nx;
    logic       key_hit;

    assign key_hit = io_wr && (io_addr == KEY_ADDR);
    assign open    = (st_q == KS_OPEN);

    // Next-state logic of the key sequence.
    always_comb begin
        st_nx  = st_q;
        sel_nx = pair_sel;
        if (st_q == KS_OPEN) begin
            if (relock) st_nx = KS_IDLE;
        end else if (io_wr || io_rd) begin
            st_nx = KS_IDLE;
            if (key_hit) begin
                case (st_q)
                    KS_IDLE: if (io_wdata == KEY_B0) st_nx = KS_GOT1;
                    KS_GOT1: if (io_wdata == KEY_B1) st_nx = KS_GOT2;
                    KS_GOT2: if (io_wdata == KEY_B2) st_nx = KS_GOT3;
                    KS_GOT3: begin
                        if (io_wdata == KEY_SEL0) begin
                            st_nx  = KS_OPEN;
                            sel_nx = 1'b0;
                        end else if (io_wdata == KEY_SEL1) begin
                            st_nx  = KS_OPEN;
                            sel_nx = 1'b1;
                        end
                    end
                    default: st_nx = KS_IDLE;
                endcase
            end
        end
    end

    // State and pair-select registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= KS_IDLE;
            pair_sel <= 1'b0;
        end else begin
            st_q     <= st_nx;
            pair_sel <= sel_nx;
        end
    end

    AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open) |-> $past(io_wr && io_addr == KEY_ADDR &&
                              (io_wdata == KEY_SEL0 || io_wdata == KEY_SEL1))); // R2

    AST_FOREIGN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (!open && (io_rd || (io_wr && io_addr != KEY_ADDR))) |=> (st_q == KS_IDLE)); // R3

endmodule

// File: rtl/cfg_reg_file.sv
// Register file: index register, logical device number, identification
// and version reads, relock decode, and the device-register strobe port.
// Assumes the read data is taken combinationally while io_rd is high.
module cfg_reg_file
    import cfg_unlock_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] PAIR0_BASE = 'h2E,
    parameter logic [ADDR_W-1:0] PAIR1_BASE = 'h4E,
    parameter logic [7:0]        DEV_LDN    = 8'h10,
    parameter logic [7:0]        ID_HI      = 8'h87,
    parameter logic [7:0]        ID_LO      = 8'h06,
    parameter logic [3:0]        VERSION    = 4'h0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               io_wr,
    input  logic               io_rd,
    input  logic [ADDR_W-1:0]  io_addr,
    input  logic [DATA_W-1:0]  io_wdata,
    output logic [DATA_W-1:0]  io_rdata,
    input  logic               open,
    input  logic               pair_sel,
    input  logic [STRAP_W-1:0] strap_q,
    output logic               relock,
    output logic               dev_wr,
    output logic               dev_rd,
    output logic [DATA_W-1:0]  dev_idx,
    output logic [DATA_W-1:0]  dev_wdata,
    input  logic [DATA_W-1:0]  dev_rdata
);

    localparam logic [ADDR_W-1:0] PAIR0_DATA = PAIR0_BASE + 1'b1;
    localparam logic [ADDR_W-1:0] PAIR1_DATA = PAIR1_BASE + 1'b1;

    logic [DATA_W-1:0] index_q, ldn_q;
    logic [ADDR_W-1:0] idx_addr, dat_addr;
    logic              hit_idx, hit_dat, cfg_port, in_dev, dev_match;

    assign idx_addr  = pair_sel ? PAIR1_BASE : PAIR0_BASE;
    assign dat_addr  = pair_sel ? PAIR1_DATA : PAIR0_DATA;
    assign hit_idx   = open && (io_addr == idx_addr);
    assign hit_dat   = open && (io_addr == dat_addr);
    assign cfg_port  = (io_addr == PAIR0_BASE) || (io_addr == PAIR0_DATA) ||
                       (io_addr == PAIR1_BASE) || (io_addr == PAIR1_DATA);
    assign in_dev    = (index_q >= IDX_DEV_BASE);
    assign dev_match = (ldn_q == DEV_LDN);

    // Index selection from index-port writes.
    always_ff @(posedge clk) begin
        if (!rst_n)                index_q <= '0;
        else if (io_wr && hit_idx) index_q <= io_wdata;
    end

    // Logical device number register.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      ldn_q <= '0;
        else if (io_wr && hit_dat && index_q == IDX_LDN) ldn_q <= io_wdata;
    end

    // Relock from the exit bit or a strap-compare mismatch.
    always_comb begin
        relock = 1'b0;
        if (io_wr && hit_dat) begin
            if (index_q == IDX_EXIT && io_wdata[EXIT_BIT])                         relock = 1'b1;
            if (index_q == IDX_VER  && io_wdata[STRAP_LSB +: STRAP_W] != strap_q)  relock = 1'b1;
        end
    end

    // Device-register write side.
    assign dev_wr    = io_wr && hit_dat && in_dev && dev_match;
    assign dev_idx   = index_q;
    assign dev_wdata = io_wdata;

    // Read multiplexer and device read strobe.
    always_comb begin
        io_rdata = '0;
        dev_rd   = 1'b0;
        if (io_rd) begin
            if (!open && cfg_port) begin
                io_rdata = '1;
            end else if (hit_idx) begin
                io_rdata = index_q;
            end else if (hit_dat) begin
                if (in_dev) begin
                    if (dev_match) begin
                        io_rdata = dev_rdata;
                        dev_rd   = 1'b1;
                    end
                end else begin
                    case (index_q)
                        IDX_LDN:   io_rdata = ldn_q;
                        IDX_ID_HI: io_rdata = ID_HI;
                        IDX_ID_LO: io_rdata = ID_LO;
                        IDX_VER:   io_rdata = {4'h0, VERSION};
                        default:   io_rdata = '0;
                    endcase
                end
            end
        end
    end

    AST_DEV_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_wr || dev_rd) |-> (ldn_q == DEV_LDN && index_q >= IDX_DEV_BASE)); // R5

    AST_LOCKED_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (!open && io_rd && cfg_port) |-> (io_rdata == 8'hFF)); // R9

    AST_LOCKED_INDEX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !open |=> $stable(index_q) && $stable(ldn_q)); // R9

endmodule

// File: rtl/cfg_unlock_ctrl.sv
// Top: key-unlocked configuration controller. Joins the strap latch, the
// key checker and the register file. Assumes a decoded single-byte I/O
// front end with at most one strobe per cycle.
module cfg_unlock_ctrl
    import cfg_unlock_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] PAIR0_BASE = 'h2E,
    parameter logic [ADDR_W-1:0] PAIR1_BASE = 'h4E,
    parameter logic [7:0]        DEV_LDN    = 8'h10,
    parameter logic [7:0]        ID_HI      = 8'h87,
    parameter logic [7:0]        ID_LO      = 8'h06,
    parameter logic [3:0]        VERSION    = 4'h0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               io_wr,
    input  logic               io_rd,
    input  logic [ADDR_W-1:0]  io_addr,
    input  logic [DATA_W-1:0]  io_wdata,
    output logic [DATA_W-1:0]  io_rdata,
    input  logic [STRAP_W-1:0] strap_pins,
    output logic               cfg_open,
    output logic               dev_wr,
    output logic               dev_rd,
    output logic [DATA_W-1:0]  dev_idx,
    output logic [DATA_W-1:0]  dev_wdata,
    input  logic [DATA_W-1:0]  dev_rdata
);

    logic [STRAP_W-1:0] strap_q;
    logic               relock, pair_sel;

    cfg_strap_latch u_strap (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_pins (strap_pins),
        .strap_q    (strap_q)
    );

    cfg_key_fsm #(
        .ADDR_W   (ADDR_W),
        .KEY_ADDR (PAIR0_BASE),
        .KEY_B0   (ID_HI),
        .KEY_B1   (ID_LO)
    ) u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .relock   (relock),
        .open     (cfg_open),
        .pair_sel (pair_sel)
    );

    cfg_reg_file #(
        .ADDR_W     (ADDR_W),
        .PAIR0_BASE (PAIR0_BASE),
        .PAIR1_BASE (PAIR1_BASE),
        .DEV_LDN    (DEV_LDN),
        .ID_HI      (ID_HI),
        .ID_LO      (ID_LO),
        .VERSION    (VERSION)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_wr     (io_wr),
        .io_rd     (io_rd),
        .io_addr   (io_addr),
        .io_wdata  (io_wdata),
        .io_rdata  (io_rdata),
        .open      (cfg_open),
        .pair_sel  (pair_sel),
        .strap_q   (strap_q),
        .relock    (relock),
        .dev_wr    (dev_wr),
        .dev_rd    (dev_rd),
        .dev_idx   (dev_idx),
        .dev_wdata (dev_wdata),
        .dev_rdata (dev_rdata)
    );

    AST_EXIT_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && io_wr && io_addr == (pair_sel ? PAIR1_BASE : PAIR0_BASE) + 1'b1 &&
         u_regs.index_q == IDX_EXIT && io_wdata[EXIT_BIT]) |=> !cfg_open); // R4

    AST_STRAP_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && io_wr && io_addr == (pair_sel ? PAIR1_BASE : PAIR0_BASE) + 1'b1 &&
         u_regs.index_q == IDX_VER &&
         io_wdata[STRAP_LSB +: STRAP_W] != strap_q) |=> !cfg_open); // R7

endmodule

// File: tb/cfg_unlock_ctrl_bench.sv
// Bench: sweeps key bytes, index values, global indexes and strap values
// with expected results computed from the requirements.
module cfg_unlock_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [1:0]  strap_pins = 2'b10;
    logic        cfg_open, dev_wr, dev_rd;
    logic [7:0]  dev_idx, dev_wdata, dev_rdata;

    int n_chk = 0, n_fail = 0;
    logic       s_dev_wr, s_dev_rd;
    logic [7:0] s_dev_idx, s_dev_wdata, r;

    assign dev_rdata = dev_idx ^ 8'h5A;

    always #4 clk = ~clk;

    cfg_unlock_ctrl u_cfg_unlock_ctrl (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .strap_pins(strap_pins), .cfg_open(cfg_open), .dev_wr(dev_wr),
        .dev_rd(dev_rd), .dev_idx(dev_idx), .dev_wdata(dev_wdata),
        .dev_rdata(dev_rdata)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        #1;
        s_dev_wr = dev_wr; s_dev_idx = dev_idx; s_dev_wdata = dev_wdata;
        @(posedge clk); #1;
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_rd = 1'b1; io_addr = a;
        #1;
        d = io_rdata; s_dev_rd = dev_rd;
        @(posedge clk); #1;
        io_rd = 1'b0;
    endtask

    task automatic key(input logic [7:0] last);
        wr(16'h2E, 8'h87); wr(16'h2E, 8'h06); wr(16'h2E, 8'h55); wr(16'h2E, last);
    endtask

    task automatic cfg_wr(input logic [15:0] base, input logic [7:0] idx, input logic [7:0] d);
        wr(base, idx); wr(base + 16'd1, d);
    endtask

    task automatic cfg_rd(input logic [15:0] base, input logic [7:0] idx, output logic [7:0] d);
        wr(base, idx); rd(base + 16'd1, d);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1/R8: reset with straps 10, then move the pins
        repeat (3) @(posedge clk);
        #1 chk("R1 open during reset", {7'b0, cfg_open}, 8'h00);
        rst_n = 1'b1;
        strap_pins = 2'b01;
        #1 chk("R1 open after reset", {7'b0, cfg_open}, 8'h00);
        rd(16'h2F, r); chk("R9 locked read 2F", r, 8'hFF);
        rd(16'h4F, r); chk("R9 locked read 4F", r, 8'hFF);
        rd(16'h2E, r); chk("R9 locked read 2E", r, 8'hFF);
        rd(16'h4E, r); chk("R9 locked read 4E", r, 8'hFF);

        // R9: locked writes ignored, yet a full key still opens afterwards
        wr(16'h4E, 8'h07); wr(16'h4F, 8'h33); wr(16'h2F, 8'h44);
        key(8'hAA);
        chk("R2 open via AA", {7'b0, cfg_open}, 8'h01);
        rd(16'h4E, r); chk("R1 R9 index unchanged", r, 8'h00);
        cfg_rd(16'h4E, 8'h07, r); chk("R1 R9 ldn unchanged", r, 8'h00);
        rd(16'h2F, r); chk("R2 unselected pair reads 00", r, 8'h00);
        cfg_wr(16'h4E, 8'h02, 8'h02);
        chk("R4 exit via pair 4E", {7'b0, cfg_open}, 8'h00);

        // R2: sweep every fourth key byte
        for (int v = 0; v < 256; v++) begin
            key(v[7:0]);
            if (v == 8'h55 || v == 8'hAA) begin
                chk("R2 valid last byte opens", {7'b0, cfg_open}, 8'h01);
                if (v == 8'h55) begin
                    cfg_wr(16'h2E, 8'h02, 8'h02);
                    chk("R4 exit relocks pair 2E", {7'b0, cfg_open}, 8'h00);
                end else begin
                    cfg_wr(16'h4E, 8'h02, 8'h02);
                    chk("R4 exit relocks pair 4E", {7'b0, cfg_open}, 8'h00);
                end
            end else begin
                chk("R2 bad last byte stays locked", {7'b0, cfg_open}, 8'h00);
            end
        end

        // R3: interruptions restart key entry
        wr(16'h2E, 8'h87); rd(16'h80, r); wr(16'h2E, 8'h06); wr(16'h2E, 8'h55); wr(16'h2E, 8'h55);
        chk("R3 read interrupts key", {7'b0, cfg_open}, 8'h00);
        wr(16'h2E, 8'h87); wr(16'h2E, 8'h06); wr(16'h61, 8'h55); wr(16'h2E, 8'h55); wr(16'h2E, 8'h55);
        chk("R3 foreign write interrupts key", {7'b0, cfg_open}, 8'h00);
        wr(16'h2E, 8'h87); wr(16'h2E, 8'h87); wr(16'h2E, 8'h06); wr(16'h2E, 8'h55); wr(16'h2E, 8'h55);
        chk("R3 repeated 87 restarts", {7'b0, cfg_open}, 8'h00);
        wr(16'h2E, 8'h99); key(8'h55);
        chk("R3 full key after wrong byte opens", {7'b0, cfg_open}, 8'h01);

        // R10: index readback for all values
        for (int v = 0; v < 256; v++) begin
            wr(16'h2E, v[7:0]); rd(16'h2E, r);
            chk("R10 index readback", r, v[7:0]);
        end

        // R6/R11/R7: global index reads, writes to undefined ignored
        for (int i = 0; i < 8'h30; i++) begin
            logic [7:0] e;
            e = (i == 8'h20) ? 8'h87 : (i == 8'h21) ? 8'h06 : 8'h00;
            if (i != 8'h02 && i != 8'h07 && i != 8'h22) cfg_wr(16'h2E, i[7:0], 8'hC3);
            cfg_rd(16'h2E, i[7:0], r);
            chk("R6 R7 R11 global index read", r, e);
        end

        // R4: bit 1 clear has no effect
        cfg_wr(16'h2E, 8'h02, 8'hFD);
        chk("R4 bit1 clear keeps open", {7'b0, cfg_open}, 8'h01);

        // R5: device gating
        cfg_wr(16'h2E, 8'h07, 8'h11);
        cfg_rd(16'h2E, 8'h40, r); chk("R5 wrong ldn read 00", r, 8'h00);
        chk("R5 wrong ldn no dev_rd", {7'b0, s_dev_rd}, 8'h00);
        cfg_wr(16'h2E, 8'h40, 8'h3C); chk("R5 wrong ldn no dev_wr", {7'b0, s_dev_wr}, 8'h00);
        cfg_wr(16'h2E, 8'h07, 8'h10);
        cfg_rd(16'h2E, 8'h07, r); chk("R5 ldn readback", r, 8'h10);
        cfg_rd(16'h2E, 8'h40, r); chk("R5 dev read data", r, 8'h40 ^ 8'h5A);
        chk("R5 dev_rd pulse", {7'b0, s_dev_rd}, 8'h01);
        cfg_wr(16'h2E, 8'h30, 8'h3C);
        chk("R5 dev_wr pulse", {7'b0, s_dev_wr}, 8'h01);
        chk("R5 dev_idx", s_dev_idx, 8'h30);
        chk("R5 dev_wdata", s_dev_wdata, 8'h3C);
        cfg_rd(16'h2E, 8'h2F, r); chk("R5 R11 index 2F not device", r, 8'h00);
        chk("R5 no dev_rd below 30", {7'b0, s_dev_rd}, 8'h00);

        // R7/R8: strap compare uses the reset-time value 10
        for (int s = 0; s < 4; s++) begin
            if (!cfg_open) key(8'h55);
            cfg_wr(16'h2E, 8'h22, {2'b00, s[1:0], 4'h0});
            chk("R7 R8 strap compare", {7'b0, cfg_open}, (s == 2) ? 8'h01 : 8'h00);
        end

        // Relock then key on the very next cycle
        if (!cfg_open) key(8'h55);
        cfg_wr(16'h2E, 8'h22, 8'h30);
        key(8'hAA);
        chk("R3 R7 key right after relock opens", {7'b0, cfg_open}, 8'h01);

        finish_run();
    end

endmodule